// File: doc/BRIEF.md
# Call and Interrupt Return Stack Controller

This block moves the program counter and the carry and zero flags to and from a byte-wide data RAM on four events: interrupt acknowledge, subroutine call, subroutine return and interrupt return. The stack sits in ordinary data RAM. It starts at address 0x00 after reset and grows toward higher addresses under an 8-bit pointer. Every save or restore takes two single-byte RAM accesses. The block also owns the global interrupt-enable flag.

The instruction decoder pulses one event strobe for one clock while the block is idle. The block then drives a simple synchronous RAM port and returns the restored program counter, and for an interrupt return the restored flags, together with load strobes. A one-cycle done pulse marks the end of each sequence. Firmware can also overwrite the stack pointer with an accumulator value through a separate write strobe.

Top module: `ret_stack_ctrl`

## Requirements
- R1: After reset the stack pointer is 0x00, interrupt-enable is 0, busy is low and no RAM access is driven.
- R2: A save (interrupt acknowledge or call) writes the low frame byte at address SP, then the high frame byte at SP+1 in the next cycle. The pointer advances by one per write, two in total.
- R3: The low frame byte is PC[7:0]. The high frame byte has carry in bit 7, zero in bit 6, 0 in bit 5 and PC[12:8] in bits 4..0.
- R4: Interrupt acknowledge clears interrupt-enable in the cycle after it is accepted, and it saves the PC and both flags that were presented with the strobe.
- R5: A subroutine call saves exactly as R2/R3 and leaves interrupt-enable unchanged.
- R6: A return reads address SP-1 first (the high byte), then SP-2 (the low byte), and ends with the pointer lowered by two. On a subroutine return the restored PC is presented with pc_load_o high and flags_load_o low.
- R7: An interrupt return restores the PC and both flags, with pc_load_o and flags_load_o high. Interrupt-enable becomes 1 in the cycle after its done pulse.
- R8: sp_wr_i loads sp_wdata_i into the pointer when the block is idle and no event strobe is present. It is ignored while busy and also when an event strobe arrives in the same cycle.
- R9: The pointer wraps modulo 256 on increment and decrement: a save from 0xFF writes 0xFF then 0x00.
- R10: The block takes an event in the idle cycle and raises busy from the next cycle. Two access cycles follow, then one cycle with done_o high, after which it is idle again.
- R11: Event strobes that arrive while busy are ignored. Of simultaneous strobes in idle exactly one is taken, in the priority interrupt acknowledge, call, return, interrupt return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| reti_i | input | 1 | Interrupt return strobe |
| sp_wr_i | input | 1 | Direct stack pointer write strobe |
| sp_wdata_i | input | 8 | Value for the direct pointer write |
| pc_i | input | 13 | PC of the next instruction, sampled with an event |
| carry_i | input | 1 | Carry flag, sampled with an event |
| zero_i | input | 1 | Zero flag, sampled with an event |
| pc_o | output | 13 | Restored PC, valid while pc_load_o is high |
| carry_o | output | 1 | Restored carry, valid while flags_load_o is high |
| zero_o | output | 1 | Restored zero, valid while flags_load_o is high |
| pc_load_o | output | 1 | Load the restored PC |
| flags_load_o | output | 1 | Load the restored flags |
| ie_o | output | 1 | Global interrupt-enable |
| sp_o | output | 8 | Current stack pointer |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable; data returns next cycle |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
A direct pointer write and an event strobe can land in the same idle cycle, and so can two event strobes. The bench raises a pointer write together with a call, and an interrupt acknowledge together with a call. Its per-cycle model expects the pointer to follow only the accepted save and expects the higher-priority event to be sequenced. The same model also expects a return strobe and a pointer write sent during a running save to leave no trace on the pointer, the RAM port or the done pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {OP_IRQ, OP_CALL, OP_RET, OP_RETI} stk_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2, ST_FIN} stk_st_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  input  logic            load_i,
  input  logic [SP_W-1:0] load_val_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] sp_dec_o
);
  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (inc_i)  sp_q <= sp_q + SP_W'(1);
    else if (dec_i)  sp_q <= sp_q - SP_W'(1);
    else if (load_i) sp_q <= load_val_i;
  end

  assign sp_o     = sp_q;
  assign sp_dec_o = sp_q - SP_W'(1);

  AST_PTR_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({inc_i, dec_i, load_i}) <= 1); // R8
  AST_PTR_INC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> sp_q == SP_W'($past(sp_q) + SP_W'(1))); // R9
  AST_PTR_DEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> sp_q == SP_W'($past(sp_q) - SP_W'(1))); // R9
endmodule

// File: rtl/stk_frame.sv
module stk_frame #(
  parameter int PC_W = 13,
  parameter int D_W  = 8
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            carry_i,
  input  logic            zero_i,
  input  logic [D_W-1:0]  hi_i,
  input  logic [D_W-1:0]  lo_i,
  output logic [D_W-1:0]  save_lo_o,
  output logic [D_W-1:0]  save_hi_o,
  output logic [PC_W-1:0] pc_o,
  output logic            carry_o,
  output logic            zero_o,
  output logic            pad_ok_o
);
  localparam int HI_W = PC_W - D_W;
  localparam int PAD  = D_W - 2 - HI_W;

  assign save_lo_o = pc_i[D_W-1:0];
  assign pc_o      = {hi_i[HI_W-1:0], lo_i};
  assign carry_o   = hi_i[D_W-1];
  assign zero_o    = hi_i[D_W-2];

  generate
    if (PAD > 0) begin : g_pad
      assign save_hi_o = {carry_i, zero_i, {PAD{1'b0}}, pc_i[PC_W-1:D_W]};
      assign pad_ok_o  = (hi_i[D_W-3:HI_W] == '0);
    end else begin : g_nopad
      assign save_hi_o = {carry_i, zero_i, pc_i[PC_W-1:D_W]};
      assign pad_ok_o  = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    irq_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    reti_i,
  input  logic    sp_wr_i,
  output stk_st_e state_o,
  output stk_op_e op_o,
  output logic    accept_o,
  output logic    save_o,
  output logic    sp_inc_o,
  output logic    sp_dec_o,
  output logic    sp_load_o,
  output logic    ram_we_o,
  output logic    ram_re_o,
  output logic    hi_cap_o,
  output logic    done_o,
  output logic    pc_load_o,
  output logic    flags_load_o,
  output logic    ie_o
);
  stk_st_e state_q;
  stk_op_e op_q, op_nxt;
  logic    any_ev, is_save, in_acc, ie_q;

  assign any_ev = irq_i | call_i | ret_i | reti_i;
  assign accept_o = (state_q == ST_IDLE) && any_ev;

  always_comb begin
    if (irq_i)       op_nxt = OP_IRQ;
    else if (call_i) op_nxt = OP_CALL;
    else if (ret_i)  op_nxt = OP_RET;
    else             op_nxt = OP_RETI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_IRQ;
    end else begin
      case (state_q)
        ST_IDLE: if (any_ev) begin
          state_q <= ST_ACC1;
          op_q    <= op_nxt;
        end
        ST_ACC1: state_q <= ST_ACC2;
        ST_ACC2: state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ie_q <= 1'b0;
    else if (accept_o && op_nxt == OP_IRQ)      ie_q <= 1'b0;
    else if (state_q == ST_FIN && op_q == OP_RETI) ie_q <= 1'b1;
  end

  assign is_save      = (op_q == OP_IRQ) || (op_q == OP_CALL);
  assign in_acc       = (state_q == ST_ACC1) || (state_q == ST_ACC2);
  assign save_o       = is_save;
  assign ram_we_o     = in_acc && is_save;
  assign ram_re_o     = in_acc && !is_save;
  assign sp_inc_o     = ram_we_o;
  assign sp_dec_o     = ram_re_o;
  assign sp_load_o    = (state_q == ST_IDLE) && !any_ev && sp_wr_i;
  assign hi_cap_o     = (state_q == ST_ACC2) && !is_save;
  assign done_o       = (state_q == ST_FIN);
  assign pc_load_o    = done_o && !is_save;
  assign flags_load_o = done_o && (op_q == OP_RETI);
  assign state_o      = state_q;
  assign op_o         = op_q;
  assign ie_o         = ie_q;

  AST_IE_CLR_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && irq_i) |=> !ie_q); // R4
  AST_CALL_KEEPS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && call_i && !irq_i) |=> ie_q == $past(ie_q)); // R5
  AST_IE_AFTER_RETI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_load_o |=> ie_q); // R7
  AST_BUSY_HOLDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(op_q) || $past(state_q) == ST_FIN); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RET_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && op_q == OP_RET) |-> !flags_load_o); // R6
endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import stk_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int SP_W = 8,
  parameter int D_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_ack_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            sp_wr_i,
  input  logic [SP_W-1:0] sp_wdata_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            carry_i,
  input  logic            zero_i,
  output logic [PC_W-1:0] pc_o,
  output logic            carry_o,
  output logic            zero_o,
  output logic            pc_load_o,
  output logic            flags_load_o,
  output logic            ie_o,
  output logic [SP_W-1:0] sp_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [SP_W-1:0] ram_addr_o,
  output logic            ram_we_o,
  output logic            ram_re_o,
  output logic [D_W-1:0]  ram_wdata_o,
  input  logic [D_W-1:0]  ram_rdata_i
);
  stk_st_e         state;
  stk_op_e         op;
  logic            accept, save, sp_inc, sp_dec, sp_load, hi_cap, pad_ok;
  logic [SP_W-1:0] sp, sp_m1;
  logic [PC_W-1:0] pc_q;
  logic            carry_q, zero_q;
  logic [D_W-1:0]  hi_q, save_lo, save_hi;

  stk_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .irq_i(irq_ack_i), .call_i, .ret_i, .reti_i, .sp_wr_i,
    .state_o(state), .op_o(op), .accept_o(accept), .save_o(save),
    .sp_inc_o(sp_inc), .sp_dec_o(sp_dec), .sp_load_o(sp_load),
    .ram_we_o, .ram_re_o, .hi_cap_o(hi_cap), .done_o,
    .pc_load_o, .flags_load_o, .ie_o
  );

  stk_ptr #(.SP_W(SP_W)) u_ptr (
    .clk_i, .rst_ni,
    .inc_i(sp_inc), .dec_i(sp_dec), .load_i(sp_load), .load_val_i(sp_wdata_i),
    .sp_o(sp), .sp_dec_o(sp_m1)
  );

  stk_frame #(.PC_W(PC_W), .D_W(D_W)) u_frame (
    .pc_i(pc_q), .carry_i(carry_q), .zero_i(zero_q),
    .hi_i(hi_q), .lo_i(ram_rdata_i),
    .save_lo_o(save_lo), .save_hi_o(save_hi),
    .pc_o, .carry_o, .zero_o, .pad_ok_o(pad_ok)
  );

  // event operands sampled at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (accept) begin
      pc_q    <= pc_i;
      carry_q <= carry_i;
      zero_q  <= zero_i;
    end
  end

  // high frame byte returns first on restore
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (hi_cap) hi_q <= ram_rdata_i;
  end

  assign ram_addr_o  = ram_re_o ? sp_m1 : sp;
  assign ram_wdata_o = (state == ST_ACC1) ? save_lo : save_hi;
  assign sp_o        = sp;
  assign busy_o      = (state != ST_IDLE);

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !ram_we_o && !ram_re_o)); // R1
  AST_SECOND_WRITE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && state == ST_ACC2) |-> ram_addr_o == SP_W'($past(ram_addr_o) + SP_W'(1))); // R2
  AST_SAVE_NET_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && save) |-> sp_o == SP_W'($past(sp_o, 3) + SP_W'(2))); // R2
  AST_RESTORE_NET_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !save) |-> sp_o == SP_W'($past(sp_o, 3) - SP_W'(2))); // R6
  AST_SECOND_READ_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && state == ST_ACC2) |-> ram_addr_o == SP_W'($past(ram_addr_o) - SP_W'(1))); // R6
  AST_FRAME_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> pad_ok); // R3
  AST_NO_ACCESS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ram_we_o && !ram_re_o && !done_o)); // R10
  AST_BUSY_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ram_we_o && !ram_re_o) |=> $stable(sp_o)); // R8
endmodule

// File: tb/ret_stack_ctrl_test.sv
module ret_stack_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 0, call = 0, ret = 0, reti = 0, spw = 0;
  logic [7:0]  spval = 0;
  logic [12:0] pc = 0;
  logic        cin = 0, zin = 0;
  logic [12:0] pc_o;
  logic        carry_o, zero_o, pc_load, flags_load, ie, busy, done, we, re;
  logic [7:0]  sp, addr, wdata, rdata;
  logic [7:0]  mem [256];

  int checks = 0, fails = 0;
  bit running = 1;

  // model state
  int m_sp, m_ie, m_ph, m_op, m_pc, m_c, m_z, m_hi;
  int m_mem [256];

  always #4 clk = ~clk;

  ret_stack_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .irq_ack_i(irq), .call_i(call), .ret_i(ret), .reti_i(reti),
    .sp_wr_i(spw), .sp_wdata_i(spval),
    .pc_i(pc), .carry_i(cin), .zero_i(zin),
    .pc_o(pc_o), .carry_o(carry_o), .zero_o(zero_o),
    .pc_load_o(pc_load), .flags_load_o(flags_load), .ie_o(ie),
    .sp_o(sp), .busy_o(busy), .done_o(done),
    .ram_addr_o(addr), .ram_we_o(we), .ram_re_o(re),
    .ram_wdata_o(wdata), .ram_rdata_i(rdata)
  );

  // synchronous RAM
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_save(int op);
    return op == 0 || op == 1;
  endfunction

  // reference model, compared every cycle away from the clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_sp = 0; m_ie = 0; m_ph = 0; m_op = 0; m_pc = 0; m_c = 0; m_z = 0; m_hi = 0;
    end else if (running) begin
      int e_we, e_re, e_addr, e_wd, e_pcl, e_fl, e_pc;
      e_we = 0; e_re = 0; e_addr = 0; e_wd = 0; e_pcl = 0; e_fl = 0; e_pc = 0;
      case (m_ph)
        1: if (is_save(m_op)) begin
             e_we = 1; e_addr = m_sp; e_wd = m_pc & 255;
           end else begin
             e_re = 1; e_addr = (m_sp + 255) & 255;
           end
        2: if (is_save(m_op)) begin
             e_we = 1; e_addr = m_sp;
             e_wd = (m_c << 7) | (m_z << 6) | (m_pc >> 8);
           end else begin
             e_re = 1; e_addr = (m_sp + 255) & 255;
           end
        3: if (!is_save(m_op)) begin
             e_pcl = 1; e_fl = (m_op == 3);
             e_pc = ((m_hi & 31) << 8) | m_mem[m_sp];
           end
        default: ;
      endcase
      chk("R10 R11", "busy", busy, m_ph != 0);
      chk("R2 R8 R9", "sp", sp, m_sp);
      chk("R4 R5 R7", "ie", ie, m_ie);
      chk("R2 R5", "ram_we", we, e_we);
      chk("R6", "ram_re", re, e_re);
      chk("R10", "done", done, m_ph == 3);
      chk("R6", "pc_load", pc_load, e_pcl);
      chk("R6 R7", "flags_load", flags_load, e_fl);
      if (e_we) begin
        chk("R2 R9", "write addr", addr, e_addr);
        chk("R3", "write data", wdata, e_wd);
      end
      if (e_re) chk("R6 R9", "read addr", addr, e_addr);
      if (e_pcl) chk("R6 R7", "restored pc", pc_o, e_pc);
      if (e_fl) begin
        chk("R7", "restored carry", carry_o, (m_hi >> 7) & 1);
        chk("R7", "restored zero", zero_o, (m_hi >> 6) & 1);
      end
      // advance
      case (m_ph)
        0: if (irq || call || ret || reti) begin
             m_op = irq ? 0 : call ? 1 : ret ? 2 : 3;
             m_pc = pc; m_c = cin; m_z = zin;
             if (irq) m_ie = 0;
             m_ph = 1;
           end else if (spw) m_sp = spval;
        1: begin
             if (is_save(m_op)) begin
               m_mem[m_sp] = e_wd; m_sp = (m_sp + 1) & 255;
             end else m_sp = (m_sp + 255) & 255;
             m_ph = 2;
           end
        2: begin
             if (is_save(m_op)) begin
               m_mem[m_sp] = e_wd; m_sp = (m_sp + 1) & 255;
             end else begin
               m_hi = m_mem[m_sp]; m_sp = (m_sp + 255) & 255;
             end
             m_ph = 3;
           end
        default: begin
             if (m_op == 3) m_ie = 1;
             m_ph = 0;
           end
      endcase
    end
  end

  task automatic drive(bit i_irq, bit i_call, bit i_ret, bit i_reti, bit i_spw,
                       logic [7:0] v, logic [12:0] p, bit c, bit z);
    @(posedge clk); #1;
    irq = i_irq; call = i_call; ret = i_ret; reti = i_reti; spw = i_spw;
    spval = v; pc = p; cin = c; zin = z;
    @(posedge clk); #1;
    irq = 0; call = 0; ret = 0; reti = 0; spw = 0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00; m_mem[i] = 0;
    end
    rdata = 8'h00;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "sp after reset", sp, 0);
        chk("R1", "ie after reset", ie, 0);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "no access after reset", {we, re}, 0);
        // R2 R3 R5: call saves
        drive(0, 1, 0, 0, 0, 0, 13'h1ABC, 1, 0); settle();
        chk("R3", "low byte stored", mem[0], 8'hBC);
        chk("R3", "high byte stored", mem[1], 8'h9A);
        // R7: interrupt return restores flags, sets ie
        drive(0, 0, 0, 1, 0, 0, 13'h0000, 0, 1); settle();
        chk("R7", "ie after reti", ie, 1);
        // R4: interrupt acknowledge clears ie
        drive(1, 0, 0, 0, 0, 0, 13'h0123, 0, 1); settle();
        chk("R4", "ie after irq", ie, 0);
        // R6: plain return
        drive(0, 0, 1, 0, 0, 0, 13'h1FFF, 1, 1); settle();
        chk("R6", "sp after ret", sp, 0);
        // R8 R9: direct write then wrap
        drive(0, 0, 0, 0, 1, 8'hFF, 0, 0, 0); settle();
        chk("R8", "sp after direct write", sp, 8'hFF);
        drive(0, 1, 0, 0, 0, 0, 13'h0F0F, 1, 1); settle();
        chk("R9", "sp after wrap", sp, 8'h01);
        chk("R9", "byte at 0xFF", mem[8'hFF], 8'h0F);
        chk("R3", "byte at 0x00", mem[8'h00], 8'hCF);
        drive(0, 0, 1, 0, 0, 0, 0, 0, 0); settle();
        chk("R9", "sp after wrap back", sp, 8'hFF);
        // R11: strobes and pointer write while busy are ignored
        @(posedge clk); #1; call = 1; pc = 13'h0555; cin = 0; zin = 0;
        @(posedge clk); #1; call = 0; ret = 1; spw = 1; spval = 8'h40;
        @(posedge clk); #1; ret = 0; spw = 0; irq = 1;
        @(posedge clk); #1; irq = 0;
        settle();
        chk("R11", "sp after busy strobes", sp, 8'h01);
        // R8 R11: pointer write with event in same cycle; priority
        drive(0, 1, 0, 1, 1, 8'h80, 13'h0AAA, 1, 0); settle();
        chk("R8", "sp write beaten by call", sp, 8'h03);
        drive(1, 1, 0, 0, 0, 0, 13'h0777, 0, 0); settle();
        chk("R11", "irq over call clears ie", ie, 0);
        drive(0, 0, 0, 1, 0, 0, 0, 0, 0); settle();
        drive(0, 0, 0, 1, 0, 0, 0, 0, 0); settle();
        chk("R7", "sp after nested reti", sp, 8'h01);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
      end
    join_any
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule